// File: doc/BRIEF.md
# Single-Channel DMA Address and Count Generator

This block is the address and count datapath of one channel of a PC-compatible DMA controller. Software programs a page, a start address, a transfer count and a mode through a byte-wide register port. On each transfer strobe the block then registers a 24-bit memory address, steps the current address by one, and decrements the current count. When the count runs out, it flags terminal count for that transfer. A single configuration input selects the channel type. A byte channel counts bytes and drives the page and address straight through. A word channel counts 16-bit words and shifts the address left by one, so bit 0 is always zero and the page LSB is dropped.

Every page, address or count write goes to both a base copy and the working copy of that register. A channel with autoinitialize enabled reloads its working copies from the base copies on the terminal-count transfer and keeps running. A channel without it stops and ignores strobes until software writes it again. Arbitration, request/acknowledge handshaking and data movement belong to the surrounding controller.

Control is a two-state machine. `ST_IDLE` is entered at reset and ignores strobes. `ST_ARMED` accepts strobes. The transitions are:
- ARM: `ST_IDLE` to `ST_ARMED`, on any page, address or count write.
- EXHAUST: `ST_ARMED` to `ST_IDLE`, on the terminal-count transfer when autoinitialize is off.
- RELOAD: `ST_ARMED` to `ST_ARMED`, on the terminal-count transfer when autoinitialize is on.
- STEP: `ST_ARMED` to `ST_ARMED`, on any other accepted strobe.

A strobe in a cycle with `wr_en` high is not accepted.

Top module: `dma_chan_addr_gen`

## Requirements
- R1: After reset, `mem_addr` is 0, `xfer_ack` and `tc` are 0, `armed` is 0, and strobes produce no `xfer_ack` until a page, address or count write has been made.
- R2: `wr_sel` encodes 0 = address, 1 = count, 2 = page, 3 = mode. Address and count writes take the low byte first and then the high byte; an internal pointer toggles on each such write. A `ptr_clr` pulse returns the pointer to low. Every page, address or count write loads both the base and the current copy.
- R3: In byte mode (`cfg_wide` = 0), the address for a transfer is `{page[7:0], addr[15:0]}`, taken from the current registers before the step.
- R4: In word mode (`cfg_wide` = 1), the address is `{page[7:1], addr[15:0], 1'b0}`. Page bit 0 is ignored, and the written address is used without any further shift.
- R5: Each accepted transfer changes the current address by exactly 1 in both modes. The direction is up when mode bit 0 is 0 and down when it is 1. Stepping wraps within 16 bits and never changes the page.
- R6: A count of N-1 gives N transfers. `tc` is high, together with `xfer_ack`, only on the transfer taken while the current count is 0.
- R7: With mode bit 1 = 0, `armed` falls after the terminal-count transfer. Later strobes give no `xfer_ack` until a page, address or count write.
- R8: With mode bit 1 = 1, the terminal-count transfer reloads current page, address and count from the base copies, and `armed` stays 1.
- R9: `mem_addr`, `xfer_ack` and `tc` are registered. They reflect a strobe sampled at one rising edge and are valid until the next edge. `xfer_ack` is a one-cycle pulse for each accepted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 0 = byte channel, 1 = shifted word channel |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (address, count, page, mode) |
| wr_data | input | 8 | Write data byte |
| ptr_clr | input | 1 | Return the low/high byte pointer to low |
| xfer_stb | input | 1 | Transfer-cycle strobe |
| mem_addr | output | 24 | Memory address of the last accepted transfer |
| xfer_ack | output | 1 | Pulse: a strobe was accepted |
| tc | output | 1 | Pulse: terminal count on this transfer |
| armed | output | 1 | Channel accepts strobes |

## Verification
The bench goes after six corner cases:
- **Address wrap.** Downward and upward runs cross the 0x0000/0xFFFF boundary. A design that carried or borrowed into the page would show a changed upper byte.
- **Word mode with an odd page.** A word channel is given an odd page. A design that kept the page LSB, failed to force bit 0 low, or shifted the address again would put wrong bits in the output.
- **Terminal count with autoinitialize.** Two complete autoinitialize cycles test the reload; stale current registers would repeat the wrong addresses or miss the second TC.
- **Terminal count without autoinitialize.** The run must end with strobes ignored; an off-by-one count would end the run a transfer early or late.
- **Byte pointer.** A stray byte write followed by a pointer clear must leave the next address pair landing low byte first.
- **Strobes before programming.** Strobes sent before any register write must give no acknowledge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_MODE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } chan_state_e;

    typedef struct packed {
        logic autoinit;
        logic dir_down;
    } chan_mode_t;

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic hi
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= 1'b0;
        end else if (clr) begin
            hi <= 1'b0;
        end else if (adv) begin
            hi <= ~hi;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                ld_addr_lo,
    input  logic                ld_addr_hi,
    input  logic                ld_cnt_lo,
    input  logic                ld_cnt_hi,
    input  logic                ld_page,
    input  logic                step,
    input  logic                dir_down,
    input  logic                reload,
    output logic [2*DATA_W-1:0] cur_addr,
    output logic [2*DATA_W-1:0] cur_cnt,
    output logic [PAGE_W-1:0]   cur_page,
    output logic                cnt_zero
);
    localparam int WORD_W = 2 * DATA_W;

    logic [WORD_W-1:0] base_addr;
    logic [WORD_W-1:0] base_cnt;
    logic [PAGE_W-1:0] base_page;
    logic [WORD_W-1:0] addr_next_step;

    assign cnt_zero       = (cur_cnt == '0);
    assign addr_next_step = dir_down ? (cur_addr - WORD_W'(1)) : (cur_addr + WORD_W'(1));

    // address pair: a write takes precedence over stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (ld_addr_lo) begin
            base_addr[DATA_W-1:0] <= wr_data;
            cur_addr[DATA_W-1:0]  <= wr_data;
        end else if (ld_addr_hi) begin
            base_addr[WORD_W-1:DATA_W] <= wr_data;
            cur_addr[WORD_W-1:DATA_W]  <= wr_data;
        end else if (reload) begin
            cur_addr <= base_addr;
        end else if (step) begin
            cur_addr <= addr_next_step;
        end
    end

    // count pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (ld_cnt_lo) begin
            base_cnt[DATA_W-1:0] <= wr_data;
            cur_cnt[DATA_W-1:0]  <= wr_data;
        end else if (ld_cnt_hi) begin
            base_cnt[WORD_W-1:DATA_W] <= wr_data;
            cur_cnt[WORD_W-1:DATA_W]  <= wr_data;
        end else if (reload) begin
            cur_cnt <= base_cnt;
        end else if (step) begin
            cur_cnt <= cur_cnt - WORD_W'(1);
        end
    end

    // page pair: never stepped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_page <= '0;
            cur_page  <= '0;
        end else if (ld_page) begin
            base_page <= wr_data[PAGE_W-1:0];
            cur_page  <= wr_data[PAGE_W-1:0];
        end else if (reload) begin
            cur_page <= base_page;
        end
    end
endmodule

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic                     wide,
    input  logic [PAGE_W-1:0]        page,
    input  logic [ADDR_W-1:0]        addr,
    output logic [ADDR_W+PAGE_W-1:0] out_addr
);
    localparam int OUT_W = ADDR_W + PAGE_W;

    logic [OUT_W-1:0] byte_map;
    logic [OUT_W-1:0] word_map;

    assign byte_map = {page, addr};
    assign word_map = {page[PAGE_W-1:1], addr, 1'b0};

    always_comb begin
        out_addr = wide ? word_map : byte_map;
    end
endmodule

// File: rtl/dma_chan_addr_gen.sv
module dma_chan_addr_gen
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wide,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_sel,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         ptr_clr,
    input  logic                         xfer_stb,
    output logic [3*DATA_W-1:0]          mem_addr,
    output logic                         xfer_ack,
    output logic                         tc,
    output logic                         armed
);
    localparam int PAGE_W = DATA_W;
    localparam int ADDR_W = 2 * DATA_W;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int OUT_W  = ADDR_W + PAGE_W;

    chan_state_e       state_q, state_d;
    chan_mode_t        mode_q;
    reg_sel_e          sel;
    logic              ptr_hi;
    logic              wr_pair;
    logic              rearm;
    logic              accept;
    logic              reload;
    logic              mode_auto;
    logic              cnt_zero;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic [PAGE_W-1:0] cur_page;
    logic [OUT_W-1:0]  map_addr;

    assign sel       = reg_sel_e'(wr_sel);
    assign wr_pair   = wr_en && (sel == SEL_ADDR || sel == SEL_CNT);
    assign rearm     = wr_en && (sel != SEL_MODE);
    assign accept    = xfer_stb && !wr_en && (state_q == ST_ARMED);
    assign mode_auto = mode_q.autoinit;
    assign reload    = accept && cnt_zero && mode_auto;
    assign armed     = (state_q == ST_ARMED);

    dma_byte_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ptr_clr),
        .adv   (wr_pair),
        .hi    (ptr_hi)
    );

    dma_chan_regs #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data    (wr_data),
        .ld_addr_lo (wr_en && sel == SEL_ADDR && !ptr_hi),
        .ld_addr_hi (wr_en && sel == SEL_ADDR &&  ptr_hi),
        .ld_cnt_lo  (wr_en && sel == SEL_CNT  && !ptr_hi),
        .ld_cnt_hi  (wr_en && sel == SEL_CNT  &&  ptr_hi),
        .ld_page    (wr_en && sel == SEL_PAGE),
        .step       (accept),
        .dir_down   (mode_q.dir_down),
        .reload     (reload),
        .cur_addr   (cur_addr),
        .cur_cnt    (cur_cnt),
        .cur_page   (cur_page),
        .cnt_zero   (cnt_zero)
    );

    dma_addr_map #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_map (
        .wide     (cfg_wide),
        .page     (cur_page),
        .addr     (cur_addr),
        .out_addr (map_addr)
    );

    // mode register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en && sel == SEL_MODE) begin
            mode_q <= chan_mode_t'(wr_data[1:0]);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: ARM, EXHAUST, RELOAD, STEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rearm) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (accept && cnt_zero && !mode_auto) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            xfer_ack <= 1'b0;
            tc       <= 1'b0;
        end else begin
            xfer_ack <= accept;
            tc       <= accept && cnt_zero;
            if (accept) begin
                mem_addr <= map_addr;
            end
        end
    end
endmodule

// File: rtl/dma_chan_addr_gen_chk.sv
module dma_chan_addr_gen_chk #(
    parameter int OUT_W = 24,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wide,
    input logic             wr_en,
    input logic             xfer_stb,
    input logic             armed,
    input logic             xfer_ack,
    input logic             tc,
    input logic [OUT_W-1:0] mem_addr,
    input logic [CNT_W-1:0] cur_cnt,
    input logic             mode_auto
);
    logic take;
    assign take = armed && xfer_stb && !wr_en;

    assert_tc_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> xfer_ack);

    assert_no_early_tc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cur_cnt != '0) |=> !tc);

    assert_idle_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && xfer_stb && !wr_en) |=> !xfer_ack);

    assert_word_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cfg_wide) |=> (xfer_ack && mem_addr[0] == 1'b0));

    assert_exhaust_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !mode_auto && cur_cnt == '0) |=> (tc && !armed));

    assert_auto_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode_auto && cur_cnt == '0) |=> (tc && armed));

    assert_ack_follows_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> $past(xfer_stb));
endmodule

bind dma_chan_addr_gen dma_chan_addr_gen_chk #(
    .OUT_W (OUT_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wide  (cfg_wide),
    .wr_en     (wr_en),
    .xfer_stb  (xfer_stb),
    .armed     (armed),
    .xfer_ack  (xfer_ack),
    .tc        (tc),
    .mem_addr  (mem_addr),
    .cur_cnt   (cur_cnt),
    .mode_auto (mode_auto)
);

// File: tb/dma_chan_addr_gen_tb.sv
module dma_chan_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wide;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [7:0]  wr_data;
    logic        ptr_clr;
    logic        xfer_stb;
    logic [23:0] mem_addr;
    logic        xfer_ack;
    logic        tc;
    logic        armed;

    always #5 clk = ~clk;

    dma_chan_addr_gen u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_wide (cfg_wide), .wr_en (wr_en),
        .wr_sel (wr_sel), .wr_data (wr_data), .ptr_clr (ptr_clr),
        .xfer_stb (xfer_stb), .mem_addr (mem_addr), .xfer_ack (xfer_ack),
        .tc (tc), .armed (armed)
    );

    typedef struct packed {
        logic [23:0] addr;
        logic        last;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    // bench reference state
    logic [15:0] m_addr, m_cnt, b_addr, b_cnt;
    logic [7:0]  m_page, b_page;
    logic        m_down, m_auto, m_armed;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] map(input logic wide, input logic [7:0] pg, input logic [15:0] ad);
        return wide ? {pg[7:1], ad, 1'b0} : {pg, ad};
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog_addr(input logic [15:0] v);
        wr(2'd0, v[7:0]); wr(2'd0, v[15:8]);
        m_addr = v; b_addr = v; m_armed = 1'b1;
    endtask

    task automatic prog_cnt(input logic [15:0] v);
        wr(2'd1, v[7:0]); wr(2'd1, v[15:8]);
        m_cnt = v; b_cnt = v; m_armed = 1'b1;
    endtask

    task automatic prog_page(input logic [7:0] v);
        wr(2'd2, v);
        m_page = v; b_page = v; m_armed = 1'b1;
    endtask

    task automatic prog_mode(input logic autoi, input logic down);
        wr(2'd3, {6'b0, autoi, down});
        m_auto = autoi; m_down = down;
    endtask

    // driver: predicts and queues, then pulses the strobe
    task automatic xfer();
        logic was_armed;
        was_armed = m_armed;
        if (m_armed) begin
            exp_q.push_back('{addr: map(cfg_wide, m_page, m_addr), last: (m_cnt == 16'h0)});
            if (m_cnt == 16'h0) begin
                if (m_auto) begin
                    m_addr = b_addr; m_cnt = b_cnt; m_page = b_page;
                end else begin
                    m_addr = m_down ? m_addr - 16'h1 : m_addr + 16'h1;
                    m_cnt  = 16'hFFFF;
                    m_armed = 1'b0;
                end
            end else begin
                m_addr = m_down ? m_addr - 16'h1 : m_addr + 16'h1;
                m_cnt  = m_cnt - 16'h1;
            end
        end
        @(negedge clk);
        xfer_stb = 1'b1;
        @(negedge clk);
        xfer_stb = 1'b0;
        if (!was_armed)
            check(xfer_ack == 1'b0, "R7 strobe ignored when not armed", {31'b0, xfer_ack}, 0);
    endtask

    // monitor: pops and compares every acknowledged transfer
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (xfer_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected xfer_ack", {8'b0, mem_addr}, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.addr, "R3/R4/R5 address", {8'b0, mem_addr}, {8'b0, e.addr});
                    check(tc == e.last, "R6 terminal count", {31'b0, tc}, {31'b0, e.last});
                end
            end else if (tc) begin
                check(1'b0, "R6 tc without xfer_ack", 1, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wide = 1'b0; wr_en = 1'b0; wr_sel = 2'd0;
        wr_data = 8'h0; ptr_clr = 1'b0; xfer_stb = 1'b0;
        m_addr = 0; m_cnt = 0; b_addr = 0; b_cnt = 0; m_page = 0; b_page = 0;
        m_down = 0; m_auto = 0; m_armed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(mem_addr == 24'h0, "R1 mem_addr at reset", {8'b0, mem_addr}, 0);
        check(xfer_ack == 1'b0 && tc == 1'b0, "R1 pulses low at reset", {30'b0, xfer_ack, tc}, 0);
        check(armed == 1'b0, "R1 not armed at reset", {31'b0, armed}, 0);
        xfer();

        // R3 R5 R6 R7: byte mode, upward, three transfers
        prog_page(8'h12); prog_addr(16'h3456); prog_cnt(16'h0002);
        check(armed == 1'b1, "R1 armed after write", {31'b0, armed}, 1);
        repeat (3) xfer();
        @(negedge clk);
        check(armed == 1'b0, "R7 stopped after tc", {31'b0, armed}, 0);
        xfer();

        // R5: downward across the 16-bit wrap, page untouched
        prog_mode(1'b0, 1'b1);
        prog_page(8'h40); prog_addr(16'h0001); prog_cnt(16'h0003);
        repeat (4) xfer();

        // R4 R5: word mode, odd page, upward wrap
        cfg_wide = 1'b1;
        prog_mode(1'b0, 1'b0);
        prog_page(8'h35); prog_addr(16'h1234); prog_cnt(16'h0000);
        xfer();
        prog_addr(16'hFFFF); prog_cnt(16'h0001);
        repeat (2) xfer();

        // R8: autoinitialize through two full cycles
        cfg_wide = 1'b0;
        prog_mode(1'b1, 1'b0);
        prog_page(8'h02); prog_addr(16'h0100); prog_cnt(16'h0001);
        repeat (4) xfer();
        @(negedge clk);
        check(armed == 1'b1, "R8 still armed after reload", {31'b0, armed}, 1);

        // R2: stray byte then pointer clear
        prog_mode(1'b0, 1'b0);
        wr(2'd0, 8'hAA);
        @(negedge clk); ptr_clr = 1'b1;
        @(negedge clk); ptr_clr = 1'b0;
        prog_page(8'h07); prog_addr(16'h5678); prog_cnt(16'h0001);
        repeat (2) xfer();

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 every expected transfer acknowledged", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule